// File: doc/BRIEF.md
# Chip-Enable-Latched Byte Memory Sequencer

This block lets synchronous logic read and write single bytes in an asynchronous parallel memory of 32K x 8. That memory takes its address only at the moment its active-low chip enable falls. A host issues one access at a time over a request/acknowledge port. The sequencer captures the address, the write data and the direction when it accepts the request. It then presents the address for a setup interval and pulls chip enable low for a fixed access window. During that window it drives write enable low for a write, or output enable low for a read. After the window it returns chip enable high for a precharge interval, so the next access always begins with a fresh falling edge.

All interval lengths are counted in clock cycles and set by parameters. On a write the sequencer drives the bidirectional data bus through a separate output and enable. On a read it keeps its drivers off and samples the memory's data in the last cycle of the access window. Its own data drivers never overlap the memory's output drive, and never turn on in the cycle right after the memory drove the bus.

Top module: `bytemem_seq`

## Requirements
- R1: While rstN is low, memCeN, memOeN and memWeN are 1, memDqOe is 0 and hostAck is 0.
- R2: memAddr does not change during any cycle with memCeN low, or between the cycle before memCeN falls and the cycle in which it falls.
- R3: Each accepted request produces exactly one period of memCeN low, and that period lasts exactly ACCESS_CYC cycles.
- R4: Between two consecutive low periods, memCeN stays high for at least PRECHG_CYC + SETUP_CYC + 2 cycles. When the next request is already waiting, the gap is exactly that many cycles.
- R5: On a write (hostWrite = 1), memWeN is low exactly while memCeN is low and memOeN stays 1. memDqOe is 1 throughout the low period, and the memory stores memDqOut, which equals the hostWdata captured at acceptance.
- R6: On a read (hostWrite = 0), memOeN is low exactly while memCeN is low, memWeN stays 1 and memDqOe stays 0. hostRdata equals memDqIn as sampled in the last low cycle, and stays valid from the acknowledge onward.
- R7: memDqOe is never 1 in a cycle in which memOeN is low, nor in the cycle right after one.
- R8: hostAck is a single-cycle pulse, one per accepted request, in the first cycle after memCeN returns high. From idle, the pulse comes SETUP_CYC + ACCESS_CYC + 1 cycles after the clock edge that first samples hostReq high.
- R9: hostAddr, hostWdata and hostWrite are captured at the edge that accepts a request, and later changes to them have no effect on that access. A request that is raised while an access or precharge is in progress waits until the sequencer is idle.
- R10: memOeN and memWeN are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Access request, held until hostAck |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 15 | Byte address |
| hostWdata | input | 8 | Write data |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | 8 | Read data, valid with hostAck on a read |
| memAddr | output | 15 | Address to the memory |
| memCeN | output | 1 | Active-low chip enable |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memDqOut | output | 8 | Data driven onto the bus |
| memDqIn | input | 8 | Data read from the bus |
| memDqOe | output | 1 | Enable for the sequencer's bus drivers |

## Verification
The embedded properties check several rules on every cycle: the exact length of each chip-enable low window, the minimum high gap before the next falling edge, address stability across the falling edge and the window, the single-cycle acknowledge, and the mutual exclusion of output enable, write enable and the sequencer's own bus drive. Other behaviour shows only in the bench's scenarios, using a memory model that withholds valid data until the access time has elapsed. These scenarios cover whether the right bytes land at the right addresses, whether read data is sampled late enough, whether host fields changed mid-access are ignored, whether the gap is exactly the minimum for back-to-back requests, and the acknowledge latency from idle.

// File: rtl/bytemem_seq_pkg.sv
`timescale 1ns/1ps
package bytemem_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_PRECHG
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture host fields this edge
    logic capture;  // sample read data this edge
    logic ceLow;    // chip enable asserted (registered)
    logic oeLow;    // output enable asserted (registered)
    logic weLow;    // write enable asserted (registered)
    logic drive;    // own data drivers on (registered)
    logic ack;      // completion pulse (registered)
  } seqStrobes_t;

endpackage

// File: rtl/bytemem_seq_ctl.sv
`timescale 1ns/1ps
module bytemem_seq_ctl
  import bytemem_seq_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int ACCESS_CYC = 14,
  parameter int PRECHG_CYC = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  logic        hostWrite,
  output seqStrobes_t stb
);

  localparam int LONG_A  = (ACCESS_CYC > PRECHG_CYC) ? ACCESS_CYC : PRECHG_CYC;
  localparam int LONGEST = (LONG_A > SETUP_CYC) ? LONG_A : SETUP_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int MIN_GAP = PRECHG_CYC + SETUP_CYC + 2;
  localparam int WATCH_W = $clog2(MIN_GAP + ACCESS_CYC + 1) + 1;

  seqState_e        state, nextState;
  logic [CNT_W-1:0] phaseCnt, phaseCntNext;
  logic             wrQ, wrNext;
  logic             ceLowQ, oeLowQ, weLowQ, driveQ, ackQ;
  logic             accessLast;

  assign accessLast = (state == ST_ACCESS) && (phaseCnt == CNT_W'(ACCESS_CYC - 1));

  always_comb begin
    nextState    = state;
    phaseCntNext = phaseCnt + 1'b1;
    wrNext       = wrQ;
    case (state)
      ST_IDLE: begin
        phaseCntNext = '0;
        if (hostReq) begin
          nextState = ST_SETUP;
          wrNext    = hostWrite;
        end
      end
      ST_SETUP: begin
        if (phaseCnt == CNT_W'(SETUP_CYC - 1)) begin
          nextState    = ST_ACCESS;
          phaseCntNext = '0;
        end
      end
      ST_ACCESS: begin
        if (accessLast) begin
          nextState    = ST_HOLD;
          phaseCntNext = '0;
        end
      end
      ST_HOLD: begin
        nextState    = ST_PRECHG;
        phaseCntNext = '0;
      end
      ST_PRECHG: begin
        if (phaseCnt == CNT_W'(PRECHG_CYC - 1)) begin
          nextState    = ST_IDLE;
          phaseCntNext = '0;
        end
      end
      default: begin
        nextState    = ST_IDLE;
        phaseCntNext = '0;
      end
    endcase
  end

  // state and glitch-free registered memory strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      wrQ      <= 1'b0;
      ceLowQ   <= 1'b0;
      oeLowQ   <= 1'b0;
      weLowQ   <= 1'b0;
      driveQ   <= 1'b0;
      ackQ     <= 1'b0;
    end else begin
      state    <= nextState;
      phaseCnt <= phaseCntNext;
      wrQ      <= wrNext;
      ceLowQ   <= (nextState == ST_ACCESS);
      oeLowQ   <= (nextState == ST_ACCESS) && !wrNext;
      weLowQ   <= (nextState == ST_ACCESS) && wrNext;
      driveQ   <= wrNext && ((nextState == ST_SETUP) || (nextState == ST_ACCESS) ||
                             (nextState == ST_HOLD));
      ackQ     <= (nextState == ST_HOLD);
    end
  end

  always_comb begin
    stb.load    = (state == ST_IDLE) && hostReq;
    stb.capture = accessLast && !wrQ;
    stb.ceLow   = ceLowQ;
    stb.oeLow   = oeLowQ;
    stb.weLow   = weLowQ;
    stb.drive   = driveQ;
    stb.ack     = ackQ;
  end

  // window watchers for the checks below
  logic [WATCH_W-1:0] lowCnt, highCnt;
  logic               seenLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
      seenLow <= 1'b0;
    end else begin
      if (ceLowQ) begin
        seenLow <= 1'b1;
        highCnt <= '0;
        if (lowCnt != '1) lowCnt <= lowCnt + 1'b1;
      end else begin
        lowCnt <= '0;
        if (highCnt != '1) highCnt <= highCnt + 1'b1;
      end
    end
  end

  // R3
  access_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ceLowQ) |-> (lowCnt == WATCH_W'(ACCESS_CYC)));

  // R4
  precharge_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ceLowQ) && seenLow) |-> (highCnt >= WATCH_W'(MIN_GAP)));

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !ackQ);

  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveQ |-> (!oeLowQ && !$past(oeLowQ)));

  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(oeLowQ && weLowQ));

endmodule

// File: rtl/bytemem_seq_dp.sv
`timescale 1ns/1ps
module bytemem_seq_dp
  import bytemem_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       stb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (stb.load) begin
        addrQ  <= hostAddr;
        wdataQ <= hostWdata;
      end
      if (stb.capture) rdataQ <= memDqIn;
    end
  end

  assign memAddr   = addrQ;
  assign memDqOut  = wdataQ;
  assign memDqOe   = stb.drive;
  assign memCeN    = !stb.ceLow;
  assign memOeN    = !stb.oeLow;
  assign memWeN    = !stb.weLow;
  assign hostRdata = rdataQ;
  assign hostAck   = stb.ack;

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ceLow |-> $stable(addrQ));

  // R5
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.weLow |-> (stb.drive && stb.ceLow));

  // R6
  read_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (stb.oeLow && stb.ceLow && !stb.drive));

  // R9
  load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (!stb.ceLow && !stb.drive && !stb.ack));

endmodule

// File: rtl/bytemem_seq.sv
`timescale 1ns/1ps
module bytemem_seq
  import bytemem_seq_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int ACCESS_CYC = 14,
  parameter int PRECHG_CYC = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  seqStrobes_t stb;

  bytemem_seq_ctl #(
    .SETUP_CYC (SETUP_CYC),
    .ACCESS_CYC(ACCESS_CYC),
    .PRECHG_CYC(PRECHG_CYC)
  ) ctl (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .stb      (stb)
  );

  bytemem_seq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .memDqIn  (memDqIn),
    .hostAck  (hostAck),
    .hostRdata(hostRdata),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe)
  );

endmodule

// File: tb/bytemem_seq_test.sv
`timescale 1ns/1ps
module bytemem_seq_test;

  localparam int TB_SETUP  = 2;
  localparam int TB_ACCESS = 14;
  localparam int TB_PRE    = 4;
  localparam int MIN_GAP   = TB_PRE + TB_SETUP + 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostReq, hostWrite;
  logic [14:0] hostAddr;
  logic [7:0]  hostWdata;
  logic        hostAck;
  logic [7:0]  hostRdata;
  logic [14:0] memAddr;
  logic        memCeN, memOeN, memWeN, memDqOe;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn = 8'h5A;

  always #2.5 clk = ~clk;

  bytemem_seq #(
    .ADDR_W(15), .DATA_W(8),
    .SETUP_CYC(TB_SETUP), .ACCESS_CYC(TB_ACCESS), .PRECHG_CYC(TB_PRE)
  ) uut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostAck(hostAck),
    .hostRdata(hostRdata), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memDqOut(memDqOut),
    .memDqIn(memDqIn), .memDqOe(memDqOe)
  );

  int testCount = 0;
  int failCount = 0;
  bit rstDone   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] initPat(input int a);
    return 8'((a * 7) ^ 8'h3C);
  endfunction

  // memory model with access-time check
  logic [7:0] memArr [int];
  int  latAddr = 0;
  int  lowRun = 0, highRun = 0, minGap = 1000000;
  bit  seenLow = 1'b0;
  logic prevCeN = 1'b1, prevOeN = 1'b1, prevAck = 1'b0;
  int  vioR2 = 0, vioR3 = 0, vioR4 = 0, vioR5 = 0, vioR7 = 0, vioR8 = 0, vioR10 = 0;
  int  ackCount = 0, reqCount = 0;

  function automatic logic [7:0] modelRead(input int a);
    return memArr.exists(a) ? memArr[a] : initPat(a);
  endfunction

  always @(negedge clk) begin
    if (rstDone) begin
      if (!memCeN) begin
        if (prevCeN) begin
          latAddr = int'(memAddr);
          if (seenLow) begin
            if (highRun < MIN_GAP) vioR4++;
            if (highRun < minGap) minGap = highRun;
          end
          lowRun = 0;
        end else if (int'(memAddr) != latAddr) vioR2++;
        lowRun++;
        if (!memWeN) begin
          if (!memDqOe || !memOeN) vioR5++;
          memArr[latAddr] = memDqOut;
        end
      end else begin
        if (!prevCeN) begin
          if (lowRun != TB_ACCESS) vioR3++;
          seenLow = 1'b1;
          highRun = 0;
        end
        highRun++;
      end
      if (memDqOe && (!memOeN || !prevOeN)) vioR7++;
      if (!memOeN && !memWeN) vioR10++;
      memDqIn = (!memCeN && !memOeN && lowRun >= TB_ACCESS) ? modelRead(latAddr) : 8'h5A;
      prevCeN = memCeN;
      prevOeN = memOeN;
    end
  end

  // scoreboard
  typedef struct {
    bit          isRead;
    logic [14:0] addr;
    logic [7:0]  data;
  } item_t;
  item_t      expQ[$];
  logic [7:0] refArr [int];

  function automatic logic [7:0] refRead(input int a);
    return refArr.exists(a) ? refArr[a] : initPat(a);
  endfunction

  always @(negedge clk) begin
    if (rstDone) begin
      if (hostAck) begin
        ackCount++;
        if (prevAck) vioR8++;
        if (expQ.size() == 0) chk(1'b0, "R8 unexpected ack", 1, 0);
        else begin
          item_t it;
          it = expQ.pop_front();
          if (it.isRead) chk(hostRdata == it.data, "R6 read data", int'(hostRdata), int'(it.data));
        end
      end
      prevAck = hostAck;
    end
  end

  task automatic doAccess(input bit wr, input logic [14:0] a, input logic [7:0] d,
                          input bit scramble, output int lat);
    item_t it;
    @(negedge clk);
    hostReq   = 1'b1;
    hostWrite = wr;
    hostAddr  = a;
    hostWdata = d;
    reqCount++;
    it.isRead = !wr;
    it.addr   = a;
    if (wr) begin
      refArr[int'(a)] = d;
      it.data = d;
    end else it.data = refRead(int'(a));
    expQ.push_back(it);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (scramble && !memCeN) begin
        hostAddr  = ~a;
        hostWdata = ~d;
      end
    end while (!hostAck && lat < 2000);
    hostReq   = 1'b0;
    hostWrite = 1'b0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int lat;
    rstN = 1'b0; hostReq = 1'b0; hostWrite = 1'b0; hostAddr = '0; hostWdata = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(memCeN == 1'b1, "R1 ceN", int'(memCeN), 1);
    chk(memOeN == 1'b1, "R1 oeN", int'(memOeN), 1);
    chk(memWeN == 1'b1, "R1 weN", int'(memWeN), 1);
    chk(memDqOe == 1'b0, "R1 dqOe", int'(memDqOe), 0);
    chk(hostAck == 1'b0, "R1 ack", int'(hostAck), 0);
    rstN = 1'b1;
    rstDone = 1'b1;
    repeat (3) @(negedge clk);

    // R8 latency from idle, R5 writes at both ends of the space
    doAccess(1'b1, 15'h0000, 8'h00, 1'b0, lat);
    chk(lat == TB_SETUP + TB_ACCESS + 1, "R8 latency", lat, TB_SETUP + TB_ACCESS + 1);
    doAccess(1'b1, 15'h7FFF, 8'hFF, 1'b0, lat);
    doAccess(1'b1, 15'h1234, 8'hA5, 1'b0, lat);
    doAccess(1'b1, 15'h4321, 8'h5A, 1'b0, lat);
    // R6 reads back, including an unwritten byte
    doAccess(1'b0, 15'h0000, 8'h00, 1'b0, lat);
    doAccess(1'b0, 15'h7FFF, 8'h00, 1'b0, lat);
    doAccess(1'b0, 15'h1234, 8'h00, 1'b0, lat);
    doAccess(1'b0, 15'h4321, 8'h00, 1'b0, lat);
    doAccess(1'b0, 15'h2222, 8'h00, 1'b0, lat);
    // R7 read followed directly by write, then read
    doAccess(1'b0, 15'h1234, 8'h00, 1'b0, lat);
    doAccess(1'b1, 15'h1234, 8'hC3, 1'b0, lat);
    doAccess(1'b0, 15'h1234, 8'h00, 1'b0, lat);
    // R9 host fields scrambled mid-access
    doAccess(1'b1, 15'h0100, 8'h77, 1'b1, lat);
    doAccess(1'b0, 15'h0100, 8'h00, 1'b0, lat);
    doAccess(1'b0, 15'h7EFF, 8'h00, 1'b0, lat);
    doAccess(1'b0, 15'h4321, 8'h00, 1'b1, lat);
    // R8 latency again after an idle gap
    repeat (10) @(negedge clk);
    doAccess(1'b0, 15'h7FFF, 8'h00, 1'b0, lat);
    chk(lat == TB_SETUP + TB_ACCESS + 1, "R8 latency after gap", lat, TB_SETUP + TB_ACCESS + 1);
    repeat (TB_PRE + 4) @(negedge clk);

    chk(vioR2 == 0, "R2 address moved under low ceN", vioR2, 0);
    chk(vioR3 == 0, "R3 access window length", vioR3, 0);
    chk(vioR4 == 0, "R4 gap too short", vioR4, 0);
    chk(minGap == MIN_GAP, "R4 back-to-back gap", minGap, MIN_GAP);
    chk(vioR5 == 0, "R5 write without drive", vioR5, 0);
    chk(vioR7 == 0, "R7 bus turnaround", vioR7, 0);
    chk(vioR8 == 0, "R8 ack wider than one cycle", vioR8, 0);
    chk(vioR10 == 0, "R10 oeN and weN both low", vioR10, 0);
    chk(ackCount == reqCount, "R9 one ack per request", ackCount, reqCount);
    chk(expQ.size() == 0, "R3 outstanding accesses", expQ.size(), 0);
    finishRun();
  end

endmodule